// File: doc/BRIEF.md
# Doorbell Queue Pair Controller

This block is the device-side engine for a pair of rings kept in host memory: a submission ring that holds 64-byte command entries, and a completion ring into which the device writes short status entries. The host places command entries in the submission ring and then writes the new tail index to a submission doorbell. The controller fetches every entry between its own head and that tail, strictly in ring order with a single read outstanding, and presents each entry on a command-execution port.

When the execution side reports that a command has finished, the controller writes a 32-bit completion entry into the next completion slot and pulses an interrupt. The entry carries the command identifier and a phase bit. The phase bit inverts each time the completion write pointer wraps, so the host can tell new entries from old ones without reading any device pointer. The host returns completion slots by writing its consumer index to a completion doorbell. Posting stalls while the completion ring is full. A doorbell value outside the ring is discarded and sets a sticky error flag.

Top module: `qp_ctrl`

## Requirements
- R1: After reset no memory read or write is requested, no command is presented, `irq` and `db_err` are low, and `done_ready` is high (head 0, write pointer 0, phase 1).
- R2: No submission entry is fetched while the device head equals the tail last written to the submission doorbell. Fetching starts only after a doorbell write moves the tail.
- R3: Each read request addresses `SQ_BASE + head*64`. At most one read is in flight. A request holds its address until it is accepted.
- R4: Fetched entries are presented on `cmd_data` in ring order and unchanged. The command identifier sits in bits [31:16] of the entry. A presented entry stays stable until `cmd_ready`.
- R5: The head wraps from DEPTH-1 to 0. The ring can carry DEPTH-1 entries, which is its full state (tail+1 mod DEPTH equals head), and all of them are executed.
- R6: A completion is written to `CQ_BASE + wp*4` with data {identifier in [31:16], status in [15:1], phase in [0]}.
- R7: The phase bit is 1 after reset and inverts each time the completion write pointer wraps from DEPTH-1 to 0.
- R8: `irq` is high for exactly the one cycle that follows each accepted completion write, and at no other time.
- R9: `done_ready` is low while (wp+1) mod DEPTH equals the host-reported completion head. A completion doorbell that frees a slot lets posting resume.
- R10: A doorbell value of DEPTH or more leaves that doorbell's pointer unchanged and sets `db_err`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sq_db_wr | input | 1 | Submission doorbell write strobe |
| sq_db_val | input | DB_W | New submission tail |
| cq_db_wr | input | 1 | Completion doorbell write strobe |
| cq_db_val | input | DB_W | New host completion head |
| rd_req_valid | output | 1 | Entry read request |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | ADDR_W | Byte address of the entry to read |
| rd_rsp_valid | input | 1 | Read data returned |
| rd_rsp_data | input | ENTRY_W | Returned command entry |
| cmd_valid | output | 1 | Command presented for execution |
| cmd_ready | input | 1 | Execution side takes the command |
| cmd_data | output | ENTRY_W | Command entry |
| done_valid | input | 1 | Execution finished |
| done_ready | output | 1 | Completion can be accepted |
| done_cid | input | 16 | Identifier of the finished command |
| done_status | input | 15 | Completion status code |
| wr_req_valid | output | 1 | Completion write request |
| wr_req_ready | input | 1 | Write request accepted |
| wr_req_addr | output | ADDR_W | Byte address of the completion slot |
| wr_req_data | output | 32 | Completion entry |
| irq | output | 1 | One-cycle interrupt pulse per completion |
| db_err | output | 1 | Sticky flag for an out-of-range doorbell |

## Verification
The bench builds the controller with DEPTH=4, DB_W=8 and ENTRY_W=64. With a four-slot ring, both pointer wraps, two phase inversions and the full states of both rings are reached within a dozen commands. An 8-bit doorbell can carry values from 4 to 255, so out-of-range writes are presented to both doorbells. Back-pressure on the read, command and write handshakes follows different cycle patterns, so held requests and a stalled completion both occur.

// File: rtl/qp_pkg.sv
package qp_pkg;
  localparam int CID_LSB = 16;
  localparam int CID_W   = 16;
  localparam int STAT_W  = 15;
  localparam int CQE_W   = CID_W + STAT_W + 1;

  typedef enum logic [1:0] {F_IDLE, F_REQ, F_WAIT, F_DISP} fetch_st_e;
  typedef enum logic {P_IDLE, P_WR} post_st_e;
endpackage

// File: rtl/qp_rst_sync.sv
module qp_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/qp_db_check.sv
module qp_db_check #(
  parameter int DEPTH = 16,
  parameter int DB_W  = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             db_wr,
  input  logic [DB_W-1:0]  db_val,
  output logic [PTR_W-1:0] ptr,
  output logic             bad
);
  logic             in_range;
  logic             load;
  logic [PTR_W-1:0] ptr_q;

  assign in_range = ({1'b0, db_val} < (DB_W+1)'(DEPTH));
  assign load     = db_wr && in_range;
  assign bad      = db_wr && !in_range;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr_q <= '0;
    else if (load) ptr_q <= db_val[PTR_W-1:0];
  end

  assign ptr = ptr_q;

  AST_BAD_DB_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> $stable(ptr_q)); // R10
endmodule

// File: rtl/qp_sq_fetch.sv
module qp_sq_fetch
  import qp_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int ADDR_W    = 32,
  parameter int ENTRY_W   = 512,
  parameter int SQE_BYTES = 64,
  parameter logic [ADDR_W-1:0] SQ_BASE = '0,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PTR_W-1:0]   tail,
  output logic               rd_req_valid,
  input  logic               rd_req_ready,
  output logic [ADDR_W-1:0]  rd_req_addr,
  input  logic               rd_rsp_valid,
  input  logic [ENTRY_W-1:0] rd_rsp_data,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic [ENTRY_W-1:0] cmd_data
);
  localparam int SQE_SHIFT = $clog2(SQE_BYTES);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  fetch_st_e        state_q, state_d;
  logic [PTR_W-1:0] head_q, head_d;
  logic             head_inc;
  logic             ent_ld;
  logic [ENTRY_W-1:0] ent_q;

  assign head_d = (head_q == LAST) ? '0 : head_q + 1'b1;

  always_comb begin
    state_d  = state_q;
    head_inc = 1'b0;
    ent_ld   = 1'b0;
    case (state_q)
      F_IDLE: if (head_q != tail) state_d = F_REQ;
      F_REQ:  if (rd_req_ready)   state_d = F_WAIT;
      F_WAIT: if (rd_rsp_valid) begin
        ent_ld  = 1'b1;
        state_d = F_DISP;
      end
      F_DISP: if (cmd_ready) begin
        head_inc = 1'b1;
        state_d  = F_IDLE;
      end
      default: state_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= F_IDLE;
      head_q  <= '0;
    end else begin
      state_q <= state_d;
      if (head_inc) head_q <= head_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ent_ld) ent_q <= rd_rsp_data;
  end

  assign rd_req_valid = (state_q == F_REQ);
  assign rd_req_addr  = SQ_BASE + (ADDR_W'(head_q) << SQE_SHIFT);
  assign cmd_valid    = (state_q == F_DISP);
  assign cmd_data     = ent_q;

  AST_FETCH_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> (head_q != tail)); // R2
  AST_RD_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr))); // R3
  AST_ONE_READ_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && rd_req_ready) |=> !rd_req_valid); // R3
  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data))); // R4
endmodule

// File: rtl/qp_cq_post.sv
module qp_cq_post
  import qp_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int ADDR_W    = 32,
  parameter int CQE_BYTES = 4,
  parameter logic [ADDR_W-1:0] CQ_BASE = '0,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PTR_W-1:0]  host_head,
  input  logic              done_valid,
  output logic              done_ready,
  input  logic [CID_W-1:0]  done_cid,
  input  logic [STAT_W-1:0] done_status,
  output logic              wr_req_valid,
  input  logic              wr_req_ready,
  output logic [ADDR_W-1:0] wr_req_addr,
  output logic [CQE_W-1:0]  wr_req_data,
  output logic              irq
);
  localparam int CQE_SHIFT = $clog2(CQE_BYTES);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  post_st_e         st_q, st_d;
  logic [PTR_W-1:0] wp_q, wp_nxt;
  logic             phase_q, phase_d;
  logic             irq_q;
  logic             full;
  logic             accept;
  logic             wr_fire;
  logic [CQE_W-2:0] cqe_q;

  assign wp_nxt  = (wp_q == LAST) ? '0 : wp_q + 1'b1;
  assign full    = (wp_nxt == host_head);
  assign accept  = done_valid && done_ready;
  assign wr_fire = wr_req_valid && wr_req_ready;
  assign phase_d = (wp_q == LAST) ? ~phase_q : phase_q;

  always_comb begin
    st_d = st_q;
    case (st_q)
      P_IDLE:  if (accept)  st_d = P_WR;
      P_WR:    if (wr_fire) st_d = P_IDLE;
      default: st_d = P_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= P_IDLE;
      wp_q    <= '0;
      phase_q <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      st_q  <= st_d;
      irq_q <= wr_fire;
      if (wr_fire) begin
        wp_q    <= wp_nxt;
        phase_q <= phase_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept) cqe_q <= {done_cid, done_status};
  end

  assign done_ready   = (st_q == P_IDLE) && !full;
  assign wr_req_valid = (st_q == P_WR);
  assign wr_req_addr  = CQ_BASE + (ADDR_W'(wp_q) << CQE_SHIFT);
  assign wr_req_data  = {cqe_q, phase_q};
  assign irq          = irq_q;

  AST_IRQ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(wr_req_valid && wr_req_ready)); // R8
  AST_PHASE_FLIPS_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && (wp_q == LAST)) |=> (phase_q != $past(phase_q))); // R7
  AST_PHASE_HOLDS_MIDRING: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && (wp_q != LAST)) |=> $stable(phase_q)); // R7
  AST_WR_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_valid && !wr_req_ready) |=> (wr_req_valid && $stable(wr_req_data) && $stable(wr_req_addr))); // R6
endmodule

// File: rtl/qp_ctrl.sv
module qp_ctrl
  import qp_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int DB_W      = 16,
  parameter int ADDR_W    = 32,
  parameter int ENTRY_W   = 512,
  parameter int SQE_BYTES = 64,
  parameter int CQE_BYTES = 4,
  parameter logic [ADDR_W-1:0] SQ_BASE = 32'h0001_0000,
  parameter logic [ADDR_W-1:0] CQ_BASE = 32'h0002_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sq_db_wr,
  input  logic [DB_W-1:0]    sq_db_val,
  input  logic               cq_db_wr,
  input  logic [DB_W-1:0]    cq_db_val,
  output logic               rd_req_valid,
  input  logic               rd_req_ready,
  output logic [ADDR_W-1:0]  rd_req_addr,
  input  logic               rd_rsp_valid,
  input  logic [ENTRY_W-1:0] rd_rsp_data,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic [ENTRY_W-1:0] cmd_data,
  input  logic               done_valid,
  output logic               done_ready,
  input  logic [15:0]        done_cid,
  input  logic [14:0]        done_status,
  output logic               wr_req_valid,
  input  logic               wr_req_ready,
  output logic [ADDR_W-1:0]  wr_req_addr,
  output logic [31:0]        wr_req_data,
  output logic               irq,
  output logic               db_err
);
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int N_DB   = 2;
  localparam int DB_SQ  = 0;
  localparam int DB_CQ  = 1;

  logic             rst_s;
  logic [N_DB-1:0]  db_wr_v;
  logic [DB_W-1:0]  db_val_v [N_DB];
  logic [PTR_W-1:0] db_ptr_v [N_DB];
  logic [N_DB-1:0]  db_bad_v;
  logic             err_q, err_d;

  qp_rst_sync u_rst (.clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_s));

  assign db_wr_v[DB_SQ]  = sq_db_wr;
  assign db_wr_v[DB_CQ]  = cq_db_wr;
  assign db_val_v[DB_SQ] = sq_db_val;
  assign db_val_v[DB_CQ] = cq_db_val;

  for (genvar g = 0; g < N_DB; g++) begin : g_db
    qp_db_check #(.DEPTH(DEPTH), .DB_W(DB_W)) u_db (
      .clk   (clk),
      .rst_n (rst_s),
      .db_wr (db_wr_v[g]),
      .db_val(db_val_v[g]),
      .ptr   (db_ptr_v[g]),
      .bad   (db_bad_v[g])
    );
  end

  assign err_d = err_q | (|db_bad_v);

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign db_err = err_q;

  qp_sq_fetch #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W),
    .SQE_BYTES(SQE_BYTES), .SQ_BASE(SQ_BASE)
  ) u_fetch (
    .clk         (clk),
    .rst_n       (rst_s),
    .tail        (db_ptr_v[DB_SQ]),
    .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready),
    .rd_req_addr (rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_data (rd_rsp_data),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_data    (cmd_data)
  );

  qp_cq_post #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .CQE_BYTES(CQE_BYTES), .CQ_BASE(CQ_BASE)
  ) u_post (
    .clk         (clk),
    .rst_n       (rst_s),
    .host_head   (db_ptr_v[DB_CQ]),
    .done_valid  (done_valid),
    .done_ready  (done_ready),
    .done_cid    (done_cid),
    .done_status (done_status),
    .wr_req_valid(wr_req_valid),
    .wr_req_ready(wr_req_ready),
    .wr_req_addr (wr_req_addr),
    .wr_req_data (wr_req_data),
    .irq         (irq)
  );

  AST_BAD_DB_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_s)
    (|db_bad_v) |=> db_err); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_s)
    db_err |=> db_err); // R10
endmodule

// File: tb/tb_qp_ctrl.sv
module tb_qp_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int D   = 4;
  localparam int DBW = 8;
  localparam int AW  = 32;
  localparam int EW  = 64;
  localparam logic [AW-1:0] SQB = 32'h0000_1000;
  localparam logic [AW-1:0] CQB = 32'h0000_8000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sq_db_wr = 1'b0, cq_db_wr = 1'b0;
  logic [DBW-1:0] sq_db_val = '0, cq_db_val = '0;
  logic rd_req_valid, rd_req_ready = 1'b0;
  logic [AW-1:0] rd_req_addr;
  logic rd_rsp_valid = 1'b0;
  logic [EW-1:0] rd_rsp_data = '0;
  logic cmd_valid, cmd_ready = 1'b0;
  logic [EW-1:0] cmd_data;
  logic done_valid = 1'b0, done_ready;
  logic [15:0] done_cid = '0;
  logic [14:0] done_status = '0;
  logic wr_req_valid, wr_req_ready = 1'b0;
  logic [AW-1:0] wr_req_addr;
  logic [31:0] wr_req_data;
  logic irq, db_err;

  qp_ctrl #(.DEPTH(D), .DB_W(DBW), .ADDR_W(AW), .ENTRY_W(EW),
            .SQ_BASE(SQB), .CQ_BASE(CQB)) dut (
    .clk(clk), .rst_n(rst_n),
    .sq_db_wr(sq_db_wr), .sq_db_val(sq_db_val),
    .cq_db_wr(cq_db_wr), .cq_db_val(cq_db_val),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .done_valid(done_valid), .done_ready(done_ready),
    .done_cid(done_cid), .done_status(done_status),
    .wr_req_valid(wr_req_valid), .wr_req_ready(wr_req_ready),
    .wr_req_addr(wr_req_addr), .wr_req_data(wr_req_data),
    .irq(irq), .db_err(db_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // host memory and execution side
  logic [EW-1:0] sq_mem [D];
  logic [15:0]   pend [$];
  int unsigned   cyc = 0;
  logic [14:0]   stat_ctr = 15'h11;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    rd_req_ready <= (cyc % 3) != 1;
    wr_req_ready <= (cyc % 4) != 2;
    cmd_ready    <= (cyc % 5) != 3;
    rd_rsp_valid <= rd_req_valid && rd_req_ready;
    rd_rsp_data  <= sq_mem[int'((rd_req_addr - SQB) >> 6) % D];
    if (cmd_valid && cmd_ready) pend.push_back(cmd_data[31:16]);
    if (done_valid && !done_ready) begin
      // hold the offered completion
    end else if (pend.size() > 0) begin
      done_valid  <= 1'b1;
      done_cid    <= pend.pop_front();
      done_status <= stat_ctr;
      stat_ctr    <= stat_ctr + 15'd3;
    end else begin
      done_valid <= 1'b0;
    end
  end

  // reference model, compared on every falling edge
  bit mon_en = 1'b0;
  int m_head = 0, m_tail = 0, m_wp = 0, m_cqh = 0;
  bit m_phase = 1'b1, m_err = 1'b0, irq_exp = 1'b0, rd_busy = 1'b0;
  int n_wr = 0;
  logic [EW-1:0] exp_cmd [$];
  logic [30:0]   exp_cqe [$];

  always @(negedge clk) if (mon_en) begin
    logic [31:0] want;
    if (m_head == m_tail) chk(!rd_req_valid, "R2 fetch while empty", rd_req_valid, 0);
    if (rd_busy) chk(!rd_req_valid, "R3 second read in flight", rd_req_valid, 0);
    chk(irq == irq_exp, "R8 irq", irq, irq_exp);
    chk(db_err == m_err, "R10 db_err", db_err, m_err);
    if (((m_wp + 1) % D) == m_cqh) chk(!done_ready, "R9 accept while full", done_ready, 0);
    irq_exp = 1'b0;
    if (rd_req_valid && rd_req_ready) begin
      chk(rd_req_addr == SQB + AW'(m_head * 64), "R3 read address", rd_req_addr, SQB + AW'(m_head * 64));
      rd_busy = 1'b1;
    end
    if (cmd_valid && cmd_ready) begin
      if (exp_cmd.size() == 0) chk(0, "R4 unexpected command", cmd_data, 0);
      else begin
        chk(cmd_data == exp_cmd[0], "R4 command entry/order", cmd_data, exp_cmd[0]);
        void'(exp_cmd.pop_front());
      end
      m_head = (m_head + 1) % D;
      rd_busy = 1'b0;
    end
    if (done_valid && done_ready) exp_cqe.push_back({done_cid, done_status});
    if (wr_req_valid && wr_req_ready) begin
      want = {(exp_cqe.size() > 0) ? exp_cqe[0] : 31'h0, m_phase};
      chk(wr_req_addr == CQB + AW'(m_wp * 4), "R6 completion address", wr_req_addr, CQB + AW'(m_wp * 4));
      chk(wr_req_data[31:1] == want[31:1], "R6 completion cid/status", wr_req_data, want);
      chk(wr_req_data[0] == m_phase, "R7 phase bit", wr_req_data[0], m_phase);
      if (exp_cqe.size() > 0) void'(exp_cqe.pop_front());
      m_wp = (m_wp + 1) % D;
      if (m_wp == 0) m_phase = ~m_phase;
      irq_exp = 1'b1;
      n_wr++;
    end
    if (sq_db_wr) begin
      if (sq_db_val < D) m_tail = sq_db_val; else m_err = 1'b1;
    end
    if (cq_db_wr) begin
      if (cq_db_val < D) m_cqh = cq_db_val; else m_err = 1'b1;
    end
  end

  // host side
  int h_tail = 0;
  int k_cmd = 0;

  task automatic place(input int n);
    for (int i = 0; i < n; i++) begin
      logic [EW-1:0] e;
      e = {32'(k_cmd * 32'h0101_0101 + 32'h5A), 16'(16'h0100 + k_cmd), 16'h0002};
      sq_mem[h_tail] = e;
      exp_cmd.push_back(e);
      h_tail = (h_tail + 1) % D;
      k_cmd++;
    end
  endtask

  task automatic ring_sq(input int v);
    @(posedge clk); sq_db_wr <= 1'b1; sq_db_val <= DBW'(v);
    @(posedge clk); sq_db_wr <= 1'b0;
  endtask

  task automatic ring_cq(input int v);
    @(posedge clk); cq_db_wr <= 1'b1; cq_db_val <= DBW'(v);
    @(posedge clk); cq_db_wr <= 1'b0;
  endtask

  task automatic wait_writes(input int n);
    while (n_wr < n) @(posedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!rd_req_valid && !cmd_valid && !wr_req_valid, "R1 no requests in reset",
        {rd_req_valid, cmd_valid, wr_req_valid}, 0);
    chk(!irq && !db_err, "R1 irq/db_err in reset", {irq, db_err}, 0);
    rst_n = 1'b1;
    idle(4);
    @(negedge clk);
    chk(done_ready == 1'b1, "R1 done_ready after reset", done_ready, 1);
    mon_en = 1'b1;
    idle(10);
    chk(n_wr == 0, "R2 nothing fetched before a doorbell", n_wr, 0);

    // single command
    place(1); ring_sq(h_tail);
    wait_writes(1);
    ring_cq(1);

    // fill the ring to DEPTH-1 entries; tail wraps to 0
    place(3); ring_sq(h_tail);
    wait_writes(4);
    idle(3);
    chk(exp_cmd.size() == 0, "R5 full ring fully executed", exp_cmd.size(), 0);
    chk(m_phase == 1'b0, "R7 phase inverted after first wrap", m_phase, 0);
    ring_cq(0);

    // completion ring fills, fourth completion must stall
    place(3); ring_sq(h_tail);
    wait_writes(7);
    place(1); ring_sq(h_tail);
    idle(40);
    chk(n_wr == 7, "R9 posting stalled while completion ring full", n_wr, 7);
    chk(done_valid && !done_ready, "R9 completion held off", {done_valid, done_ready}, 2'b10);
    ring_cq(3);
    wait_writes(8);
    chk(m_phase == 1'b1, "R7 phase back to 1 after second wrap", m_phase, 1);

    // out-of-range doorbells
    ring_sq(D);
    idle(20);
    chk(db_err == 1'b1, "R10 db_err after bad submission doorbell", db_err, 1);
    chk(n_wr == 8, "R10 bad doorbell fetched nothing", n_wr, 8);
    ring_cq(200);
    place(1); ring_sq(h_tail);
    wait_writes(9);
    idle(5);
    chk(db_err == 1'b1, "R10 db_err stays set", db_err, 1);
    chk(exp_cmd.size() == 0 && exp_cqe.size() == 0, "R5 all entries drained",
        exp_cmd.size() + exp_cqe.size(), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule